// File: doc/BRIEF.md
# Strobe-Timed External Memory Bus Master

This block connects an internal core to an external memory over an 8-bit data, 16-bit address bus. The bus is paced by a single enable strobe, E, and one read/write line. E runs all the time. Each E period lasts two input clocks: E is high for the first clock and low for the second. One external access takes exactly one E period.

The core issues a request with address, direction and write data. The block answers with an acknowledge in the clock in which it takes the request. Addresses inside a 6 KB window of the 64 KB space belong to on-chip resources. For these the block raises a select toward the internal side and starts no external E cycle, so only the remaining 58 KB ever appears on the pins. Read results from either side return in issue order on a one-clock response strobe. A float input places the address, control and data pins in high impedance while reset is held.

Top module: `membus_master`

## Requirements
- R1: While reset is held, and at its release, the pins are E = 0 and busRnw = 1 (1 means read, 0 means write), with busDataOe = 0, reqAck = 0 and rspValid = 0.
- R2: busOe is 0 while reset is held with floatMode = 1, and 1 otherwise, including after reset ends with floatMode still high.
- R3: After reset, E toggles on every clock. It is high for one clock and low for the next, starting with a high clock after the first edge.
- R4: An external request (an address outside the window) is acknowledged only in a clock in which E is low. The E cycle for that request starts with the next high clock.
- R5: An accepted external access presents its address and busRnw during both clocks of its E cycle.
- R6: For an external read, busDataIn is sampled at the end of the E-low clock. It appears on rspData with rspValid = 1 in the following clock.
- R7: For an external write, busDataOe is 0 in the E-high clock and 1 in the E-low clock, carrying the write data. It returns to 0 at the next rise of E.
- R8: A request whose address lies in [WIN_BASE, WIN_BASE+WIN_SIZE) (default 0xE800 to 0xFFFF) is acknowledged with intSel = 1 in the same clock, in either E phase. It starts no E cycle: busAddr is unchanged, busRnw stays 1 and busDataOe stays 0. Address 0xE7FF is external.
- R9: An internal read returns intRdata, sampled in its acknowledge clock, on rspData with rspValid = 1 in the next clock. An internal write gives no response.
- R10: Back-to-back external requests run on consecutive E cycles with no idle E cycle between them.
- R11: An internal request is not acknowledged while an external read is in flight. Its response follows the external read's response.
- R12: In an E cycle with no accepted access, busRnw is 1 and busDataOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| floatMode | input | 1 | Float pins while reset is held |
| reqValid | input | 1 | Core request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write data |
| reqAck | output | 1 | Request taken this clock |
| rspValid | output | 1 | Read data valid |
| rspData | output | 8 | Read data |
| intSel | output | 1 | Internal window access taken this clock |
| intRdata | input | 8 | Read data from internal resources |
| busE | output | 1 | Enable strobe |
| busRnw | output | 1 | Read/write line, 1 = read |
| busAddr | output | 16 | Address pins |
| busOe | output | 1 | Drive enable for address and control pins |
| busDataOut | output | 8 | Data pins, outgoing value |
| busDataOe | output | 1 | Drive enable for data pins |
| busDataIn | input | 8 | Data pins, incoming value |

## Verification
Every result has a fixed offset from the clock in which the request is acknowledged.

| Result | When it is due |
|---|---|
| reqAck, intSel | Same clock as the request |
| Address and busRnw | The next clock (E high) and the one after (E low) |
| Write data enable | Only in that E-low clock |
| External read response | The clock after the E-low clock, three clocks after the acknowledge |
| Internal read response | One clock after the acknowledge |

Each scenario task steps one falling edge at a time from the acknowledge clock. It checks the registered pins at that edge, and checks the combinational acknowledge one time unit after it drives the request. Every check therefore lands in the exact clock a requirement names.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef struct packed {
    logic eRise;     // next edge raises E
    logic launch;    // external access starts at next edge
    logic isWrite;   // direction of launched access
    logic drvData;   // start driving write data
    logic relData;   // release write data
    logic capExt;    // capture external read data
    logic capInt;    // capture internal read data
  } busStrobe_t;
endpackage

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
#(
  parameter int AW = 16,
  parameter int unsigned WIN_BASE = 32'hE800,
  parameter int unsigned WIN_SIZE = 6144
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  output logic          eHigh,
  output logic          reqAck,
  output logic          intSel,
  output busStrobe_t    strobe
);
  localparam int unsigned WIN_TOP = WIN_BASE + WIN_SIZE;
  localparam logic [AW:0] WIN_LO = WIN_BASE[AW:0];
  localparam logic [AW:0] WIN_HI = WIN_TOP[AW:0];

  logic cycActive, cycWrite;
  logic inWindow, rdPending, extAck, intAck;

  assign inWindow  = ({1'b0, reqAddr} >= WIN_LO) && ({1'b0, reqAddr} < WIN_HI);
  assign rdPending = cycActive && !cycWrite;
  assign extAck    = rst_n && reqValid && !inWindow && !eHigh;
  assign intAck    = rst_n && reqValid && inWindow && !rdPending;
  assign reqAck    = extAck || intAck;
  assign intSel    = intAck;

  always_comb begin
    strobe.eRise   = rst_n && !eHigh;
    strobe.launch  = extAck;
    strobe.isWrite = reqWrite;
    strobe.drvData = eHigh && cycActive && cycWrite;
    strobe.relData = !eHigh && cycActive && cycWrite;
    strobe.capExt  = !eHigh && rdPending;
    strobe.capInt  = intAck && !reqWrite;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eHigh     <= 1'b0;
      cycActive <= 1'b0;
      cycWrite  <= 1'b0;
    end else begin
      eHigh <= !eHigh;
      if (!eHigh) begin
        cycActive <= extAck;
        cycWrite  <= extAck && reqWrite;
      end
    end
  end
endmodule

// File: rtl/membus_dpath.sv
module membus_dpath
  import membus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  busStrobe_t    strobe,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] busDataIn,
  input  logic [DW-1:0] intRdata,
  output logic [AW-1:0] busAddr,
  output logic          busRnw,
  output logic [DW-1:0] busDataOut,
  output logic          busDataOe,
  output logic          rspValid,
  output logic [DW-1:0] rspData
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busAddr    <= '0;
      busRnw     <= 1'b1;
      busDataOut <= '0;
      busDataOe  <= 1'b0;
      rspValid   <= 1'b0;
      rspData    <= '0;
    end else begin
      if (strobe.eRise) begin
        busRnw <= strobe.launch ? !strobe.isWrite : 1'b1;
        if (strobe.launch) begin
          busAddr    <= reqAddr;
          busDataOut <= reqWdata;
        end
      end
      if (strobe.drvData)      busDataOe <= 1'b1;
      else if (strobe.relData) busDataOe <= 1'b0;
      rspValid <= strobe.capExt || strobe.capInt;
      if (strobe.capExt)      rspData <= busDataIn;
      else if (strobe.capInt) rspData <= intRdata;
    end
  end
endmodule

// File: rtl/membus_master.sv
module membus_master
  import membus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int unsigned WIN_BASE = 32'hE800,
  parameter int unsigned WIN_SIZE = 6144
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          floatMode,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic          reqAck,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  output logic          intSel,
  input  logic [DW-1:0] intRdata,
  output logic          busE,
  output logic          busRnw,
  output logic [AW-1:0] busAddr,
  output logic          busOe,
  output logic [DW-1:0] busDataOut,
  output logic          busDataOe,
  input  logic [DW-1:0] busDataIn
);
  busStrobe_t strobe;
  logic dataOeRaw;

  membus_ctrl #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .eHigh(busE), .reqAck(reqAck), .intSel(intSel),
    .strobe(strobe)
  );

  membus_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busDataIn(busDataIn), .intRdata(intRdata),
    .busAddr(busAddr), .busRnw(busRnw), .busDataOut(busDataOut),
    .busDataOe(dataOeRaw), .rspValid(rspValid), .rspData(rspData)
  );

  assign busOe     = !(!rst_n && floatMode);
  assign busDataOe = dataOeRaw && busOe;
endmodule

// File: rtl/membus_master_chk.sv
module membus_master_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reqAck,
  input logic          intSel,
  input logic          busE,
  input logic          busRnw,
  input logic [AW-1:0] busAddr,
  input logic          busDataOe
);
  p_e_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> busE != $past(busE));

  p_ack_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqAck && !intSel) |-> !busE);

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busE |=> ($stable(busAddr) && $stable(busRnw)));

  p_data_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busDataOe |-> (!busE && !busRnw));
endmodule

bind membus_master membus_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqAck(reqAck), .intSel(intSel), .busE(busE),
  .busRnw(busRnw), .busAddr(busAddr), .busDataOe(busDataOe)
);

// File: tb/membus_master_tb.sv
module membus_master_tb;
  logic clk = 1'b0;
  logic rst_n, floatMode, reqValid, reqWrite;
  logic [15:0] reqAddr;
  logic [7:0] reqWdata, intRdata, busDataIn;
  logic reqAck, rspValid, intSel, busE, busRnw, busOe, busDataOe;
  logic [7:0] rspData, busDataOut;
  logic [15:0] busAddr;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  membus_master u_dut (
    .clk(clk), .rst_n(rst_n), .floatMode(floatMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqAck(reqAck), .rspValid(rspValid), .rspData(rspData), .intSel(intSel),
    .intRdata(intRdata), .busE(busE), .busRnw(busRnw), .busAddr(busAddr),
    .busOe(busOe), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic waitPhase(input logic eVal);
    @(negedge clk);
    while (busE !== eVal) @(negedge clk);
  endtask

  task automatic testReset();
    rst_n = 0; floatMode = 1; reqValid = 0; reqWrite = 0; reqAddr = 0;
    reqWdata = 0; intRdata = 0; busDataIn = 0;
    repeat (2) @(negedge clk);
    chk("R2 float in reset", 32'(busOe), 0);
    floatMode = 0; #1;
    chk("R2 driven in reset", 32'(busOe), 1);
    chk("R1 E low", 32'(busE), 0);
    chk("R1 rnw high", 32'(busRnw), 1);
    chk("R1 data released", 32'(busDataOe), 0);
    chk("R1 no response", 32'(rspValid), 0);
    reqValid = 1; reqAddr = 16'h1000; #1;
    chk("R1 no ack in reset", 32'(reqAck), 0);
    reqValid = 0;
    @(negedge clk);
    floatMode = 1; rst_n = 1; #1;
    chk("R2 float ignored after reset", 32'(busOe), 1);
    floatMode = 0;
  endtask

  task automatic testToggle();
    logic prev;
    prev = busE;
    chk("R3 first clock low", 32'(busE), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R3 E toggles", 32'(busE), 32'(!prev));
      prev = busE;
    end
  endtask

  task automatic extAccess(input logic wr, input logic [15:0] addr,
                           input logic [7:0] val, input string tag);
    waitPhase(1'b0);
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqWdata = val; #1;
    chk({tag, " R4 ack in E low"}, 32'(reqAck), 1);
    @(negedge clk);
    reqValid = 0; reqWdata = 8'h00;
    chk({tag, " R3 E high"}, 32'(busE), 1);
    chk({tag, " R5 addr E high"}, 32'(busAddr), 32'(addr));
    chk({tag, " R5 rnw E high"}, 32'(busRnw), 32'(!wr));
    chk({tag, " R7 no drive E high"}, 32'(busDataOe), 0);
    @(negedge clk);
    chk({tag, " R5 addr E low"}, 32'(busAddr), 32'(addr));
    chk({tag, " R5 rnw E low"}, 32'(busRnw), 32'(!wr));
    if (wr) begin
      chk({tag, " R7 drive E low"}, 32'(busDataOe), 1);
      chk({tag, " R7 write data"}, 32'(busDataOut), 32'(val));
    end else begin
      chk({tag, " R12 read no drive"}, 32'(busDataOe), 0);
      busDataIn = val;
    end
    @(negedge clk);
    busDataIn = 8'h00;
    if (wr) begin
      chk({tag, " R7 released"}, 32'(busDataOe), 0);
      chk({tag, " R9 no write response"}, 32'(rspValid), 0);
    end else begin
      chk({tag, " R6 rsp valid"}, 32'(rspValid), 1);
      chk({tag, " R6 rsp data"}, 32'(rspData), 32'(val));
    end
    chk({tag, " R12 idle rnw"}, 32'(busRnw), 1);
    chk({tag, " R12 idle data"}, 32'(busDataOe), 0);
  endtask

  task automatic testAckPhase();
    waitPhase(1'b1);
    reqValid = 1; reqWrite = 0; reqAddr = 16'h0123; #1;
    chk("R4 no ack in E high", 32'(reqAck), 0);
    @(negedge clk); #1;
    chk("R4 ack in E low", 32'(reqAck), 1);
    @(negedge clk);
    reqValid = 0;
    chk("R4 cycle starts", 32'(busAddr), 32'h0123);
    repeat (2) @(negedge clk);
  endtask

  task automatic testBackToBack();
    waitPhase(1'b0);
    reqValid = 1; reqWrite = 1; reqAddr = 16'h3456; reqWdata = 8'hC3; #1;
    chk("R10 first ack", 32'(reqAck), 1);
    @(negedge clk);
    reqWrite = 0; reqAddr = 16'h4567; #1;
    chk("R10 second waits E high", 32'(reqAck), 0);
    chk("R10 first addr", 32'(busAddr), 32'h3456);
    @(negedge clk); #1;
    chk("R10 second ack", 32'(reqAck), 1);
    chk("R10 first write data", 32'(busDataOut), 32'hC3);
    @(negedge clk);
    reqValid = 0;
    chk("R10 second addr next cycle", 32'(busAddr), 32'h4567);
    chk("R10 second rnw", 32'(busRnw), 1);
    chk("R10 first released", 32'(busDataOe), 0);
    @(negedge clk);
    busDataIn = 8'h77;
    @(negedge clk);
    busDataIn = 8'h00;
    chk("R10 second rsp valid", 32'(rspValid), 1);
    chk("R10 second rsp data", 32'(rspData), 32'h77);
  endtask

  task automatic testInternal();
    logic [15:0] prevAddr;
    waitPhase(1'b1);
    prevAddr = busAddr;
    reqValid = 1; reqWrite = 0; reqAddr = 16'hE800; intRdata = 8'h5A; #1;
    chk("R8 ack E high", 32'(reqAck), 1);
    chk("R8 int select", 32'(intSel), 1);
    @(negedge clk);
    reqValid = 0; intRdata = 8'h00;
    chk("R9 int rsp valid", 32'(rspValid), 1);
    chk("R9 int rsp data", 32'(rspData), 32'h5A);
    chk("R8 rnw stays high", 32'(busRnw), 1);
    reqValid = 1; reqWrite = 1; reqAddr = 16'hFFFF; reqWdata = 8'hEE; #1;
    chk("R8 write ack E low", 32'(reqAck), 1);
    chk("R8 write int select", 32'(intSel), 1);
    @(negedge clk);
    reqValid = 0;
    chk("R9 no write rsp", 32'(rspValid), 0);
    chk("R8 addr unchanged", 32'(busAddr), 32'(prevAddr));
    chk("R8 rnw high", 32'(busRnw), 1);
    @(negedge clk);
    chk("R8 no data drive", 32'(busDataOe), 0);
    chk("R8 addr still unchanged", 32'(busAddr), 32'(prevAddr));
  endtask

  task automatic testOrder();
    waitPhase(1'b0);
    reqValid = 1; reqWrite = 0; reqAddr = 16'h2000; #1;
    chk("R11 ext ack", 32'(reqAck), 1);
    @(negedge clk);
    reqAddr = 16'hF000; intRdata = 8'h11; #1;
    chk("R11 int held off E high", 32'(reqAck), 0);
    @(negedge clk);
    busDataIn = 8'h99; #1;
    chk("R11 int held off E low", 32'(reqAck), 0);
    @(negedge clk);
    busDataIn = 8'h00;
    chk("R11 ext rsp first", 32'(rspData), 32'h99);
    chk("R11 ext rsp valid", 32'(rspValid), 1);
    #1;
    chk("R11 int ack after read", 32'(intSel), 1);
    @(negedge clk);
    reqValid = 0;
    chk("R11 int rsp second", 32'(rspData), 32'h11);
    chk("R11 int rsp valid", 32'(rspValid), 1);
  endtask

  initial begin
    #2000000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired (R3 run did not finish)");
    finishRun();
  end

  initial begin
    testReset();
    testToggle();
    extAccess(1'b0, 16'hE7FF, 8'hA5, "read boundary");
    extAccess(1'b1, 16'h0010, 8'h3C, "write");
    testAckPhase();
    testBackToBack();
    testInternal();
    testOrder();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule